// File: doc/BRIEF.md
# Load Element Width Converter and Placer

The block takes one element read from memory and puts it into a register file image made of 64-bit lanes. The value must already be in arithmetic order, with its least significant byte in byte 0. The element passes through three width stages in a fixed order. The first stage trims the value to the width of the original load. The second stage resizes it to a source width override, if one is given. The third stage resizes it to a destination width override, or to a full 64 bits when there is none. Each stage either zero-extends or truncates. The result therefore keeps only the bits of the narrowest of the three widths, and zeros fill the destination element above them.

The resized element is then written into the register image at a destination element index. Elements are packed in order of index, starting at byte 0 of the base register, and spill into the following registers as the index grows. The output is a write request with a register number, a data word aligned into the lane and a byte enable per lane byte. Only the bytes of the target element change in the target register. A parameter chooses between a purely combinational path and one output register stage.

Top module: `ldw_elem_placer`

## Requirements
- R1: The three size inputs share one width code: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. Bits of `ld_data` above the load width given by `ld_size` never reach `wr_data`.
- R2: When `src_ovr_en` is high, the loaded value is resized to `src_ovr_size`. A wider override zero-extends it and a narrower one truncates it. When `src_ovr_en` is low, the load width is kept.
- R3: The destination width is `dst_ovr_size` when `dst_ovr_en` is high and 64 bits otherwise. It is applied after the source stage, so the element value is `ld_data` masked to the narrowest of the load, source and destination widths.
- R4: With destination width w and index j, `wr_reg` equals `base_reg + floor(j*w/64)` modulo 2^RN_W.
- R5: The element starts at bit `(j*w) mod 64` of the lane. Lane byte 0 holds the least significant byte of the element.
- R6: `wr_be` has exactly w/8 consecutive bits set, starting at lane byte `((j*w) mod 64)/8`.
- R7: Bits of `wr_data` that lie outside the enabled bytes are zero.
- R8: When `in_valid` is low, `wr_en` is low and `wr_be` and `wr_data` are all zero. During reset, `wr_en` and `wr_be` are zero.
- R9: With OUT_REG=1 the write request appears one clock after its inputs. With OUT_REG=0 it follows the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A loaded element is present |
| ld_data | input | 64 | Loaded value in arithmetic order |
| ld_size | input | 2 | Width code of the original load |
| src_ovr_en | input | 1 | Source width override present |
| src_ovr_size | input | 2 | Source override width code |
| dst_ovr_en | input | 1 | Destination width override present |
| dst_ovr_size | input | 2 | Destination override width code |
| elem_idx | input | IDX_W | Destination element index |
| base_reg | input | RN_W | First register of the vector |
| wr_en | output | 1 | Register write request |
| wr_reg | output | RN_W | Target register number |
| wr_be | output | LANE_W/8 | Byte enables within the lane |
| wr_data | output | LANE_W | Element aligned into the lane |

## Verification
A width code taken from the wrong stage shows up directly in the data: high bits that should be zero survive, or low bits are cut off too early. A wrong placement puts the element under the wrong byte enables, or, once the packed index crosses a lane boundary, in the wrong register. All of these faults are visible at the ports in the same write request, which is one clock after the inputs with the output stage and at once without it. The bench sweeps every combination of the three widths and both override enables over twenty indices, so every lane offset and several register crossings, including wrap of the register number, are covered.

// File: rtl/ldw_pkg.sv
package ldw_pkg;
   localparam int unsigned MAX_EW = 64;
   localparam int unsigned NSTG   = 3;

   typedef enum logic [1:0] {
      EW_B = 2'd0,
      EW_H = 2'd1,
      EW_W = 2'd2,
      EW_D = 2'd3
   } ew_e;

   function automatic logic [MAX_EW-1:0] ew_mask(input ew_e w);
      case (w)
         EW_B:    return 64'h0000_0000_0000_00FF;
         EW_H:    return 64'h0000_0000_0000_FFFF;
         EW_W:    return 64'h0000_0000_FFFF_FFFF;
         default: return 64'hFFFF_FFFF_FFFF_FFFF;
      endcase
   endfunction

   function automatic logic [7:0] ew_bytes(input ew_e w);
      case (w)
         EW_B:    return 8'h01;
         EW_H:    return 8'h03;
         EW_W:    return 8'h0F;
         default: return 8'hFF;
      endcase
   endfunction
endpackage

// File: rtl/ldw_width_stage.sv
module ldw_width_stage
   import ldw_pkg::*;
(
   input  logic [MAX_EW-1:0] val_i,
   input  ew_e               dflt_i,
   input  logic              ovr_en_i,
   input  ew_e               ovr_w_i,
   output logic [MAX_EW-1:0] val_o,
   output ew_e               w_o
);
   always_comb begin
      w_o   = ovr_en_i ? ovr_w_i : dflt_i;
      val_o = val_i & ew_mask(w_o);
   end
endmodule

// File: rtl/ldw_lane_place.sv
module ldw_lane_place
   import ldw_pkg::*;
#(
   parameter int unsigned LANE_W = 64,
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned RN_W   = 5
) (
   input  logic              vld_i,
   input  logic [MAX_EW-1:0] val_i,
   input  ew_e               w_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [RN_W-1:0]   base_i,
   output logic [RN_W-1:0]   reg_o,
   output logic [LANE_W/8-1:0] be_o,
   output logic [LANE_W-1:0] data_o
);
   localparam int unsigned BE_W     = LANE_W / 8;
   localparam int unsigned LOG_LANE = $clog2(LANE_W);
   localparam int unsigned BP_W     = IDX_W + 7;

   logic [BP_W-1:0]     bitpos;
   logic [BP_W-1:0]     lane_cnt;
   logic [LOG_LANE-1:0] bit_off;
   logic [BE_W-1:0]     be_base;
   logic [LANE_W-1:0]   val_ext;

   always_comb begin
      bitpos   = BP_W'(idx_i) << (BP_W'(w_i) + BP_W'(3));
      lane_cnt = bitpos >> LOG_LANE;
      bit_off  = bitpos[LOG_LANE-1:0];
      be_base  = BE_W'(ew_bytes(w_i));
      val_ext  = LANE_W'(val_i);
      reg_o    = base_i + RN_W'(lane_cnt);
      be_o     = vld_i ? (be_base << bit_off[LOG_LANE-1:3]) : '0;
      data_o   = vld_i ? (val_ext << bit_off) : '0;
   end
endmodule

// File: rtl/ldw_elem_placer.sv
module ldw_elem_placer
   import ldw_pkg::*;
#(
   parameter int unsigned LANE_W  = 64,
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned RN_W    = 5,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [63:0]         ld_data,
   input  logic [1:0]          ld_size,
   input  logic                src_ovr_en,
   input  logic [1:0]          src_ovr_size,
   input  logic                dst_ovr_en,
   input  logic [1:0]          dst_ovr_size,
   input  logic [IDX_W-1:0]    elem_idx,
   input  logic [RN_W-1:0]     base_reg,
   output logic                wr_en,
   output logic [RN_W-1:0]     wr_reg,
   output logic [LANE_W/8-1:0] wr_be,
   output logic [LANE_W-1:0]   wr_data
);
   localparam int unsigned BE_W = LANE_W / 8;

   if (LANE_W < MAX_EW || (LANE_W & (LANE_W - 1)) != 0) begin : g_bad_lane
      $error("ldw_elem_placer: LANE_W must be a power of two of at least 64");
   end
   if (IDX_W < 1 || RN_W < 1) begin : g_bad_idx
      $error("ldw_elem_placer: IDX_W and RN_W must be at least 1");
   end

   // width stage chain: load width, source override, destination override
   logic [MAX_EW-1:0] stg_val [NSTG+1];
   ew_e               stg_w   [NSTG+1];
   logic              stg_en  [NSTG];
   ew_e               stg_ovr [NSTG];

   assign stg_val[0] = ld_data;
   assign stg_w[0]   = EW_D;
   assign stg_en[0]  = 1'b1;
   assign stg_ovr[0] = ew_e'(ld_size);
   assign stg_en[1]  = src_ovr_en;
   assign stg_ovr[1] = ew_e'(src_ovr_size);
   assign stg_en[2]  = dst_ovr_en;
   assign stg_ovr[2] = ew_e'(dst_ovr_size);

   for (genvar s = 0; s < NSTG; s++) begin : g_stage
      ew_e dflt;
      if (s == NSTG - 1) begin : g_dst_dflt
         assign dflt = EW_D;
      end else begin : g_keep_dflt
         assign dflt = stg_w[s];
      end
      ldw_width_stage u_stage (
         .val_i    (stg_val[s]),
         .dflt_i   (dflt),
         .ovr_en_i (stg_en[s]),
         .ovr_w_i  (stg_ovr[s]),
         .val_o    (stg_val[s+1]),
         .w_o      (stg_w[s+1])
      );
   end

   logic [RN_W-1:0]   c_reg;
   logic [BE_W-1:0]   c_be;
   logic [LANE_W-1:0] c_data;

   ldw_lane_place #(
      .LANE_W (LANE_W),
      .IDX_W  (IDX_W),
      .RN_W   (RN_W)
   ) u_place (
      .vld_i  (in_valid),
      .val_i  (stg_val[NSTG]),
      .w_i    (stg_w[NSTG]),
      .idx_i  (elem_idx),
      .base_i (base_reg),
      .reg_o  (c_reg),
      .be_o   (c_be),
      .data_o (c_data)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_reg  <= '0;
            wr_be   <= '0;
            wr_data <= '0;
         end else begin
            wr_en   <= in_valid;
            wr_reg  <= c_reg;
            wr_be   <= c_be;
            wr_data <= c_data;
         end
      end
   end else begin : g_out_comb
      always_comb begin
         wr_en   = in_valid & rst_n;
         wr_reg  = c_reg;
         wr_be   = rst_n ? c_be : '0;
         wr_data = c_data;
      end
   end
endmodule

// File: rtl/ldw_elem_placer_chk.sv
module ldw_elem_placer_chk #(
   parameter int unsigned LANE_W  = 64,
   parameter bit          OUT_REG = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                dst_ovr_en,
   input logic [1:0]          dst_ovr_size,
   input logic                wr_en,
   input logic [LANE_W/8-1:0] wr_be,
   input logic [LANE_W-1:0]   wr_data
);
   localparam int unsigned BE_W = LANE_W / 8;

   logic [LANE_W-1:0] be_bits;
   logic [3:0]        dst_bytes;

   always_comb begin
      for (int b = 0; b < BE_W; b++) be_bits[b*8 +: 8] = {8{wr_be[b]}};
      dst_bytes = dst_ovr_en ? (4'd1 << dst_ovr_size) : 4'd8;
   end

   // R6
   be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($countones(wr_be) == 1 || $countones(wr_be) == 2 ||
                 $countones(wr_be) == 4 || $countones(wr_be) == 8));

   // R7
   data_in_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data & ~be_bits) == '0);

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> (wr_be == '0 && wr_data == '0));

   if (OUT_REG) begin : g_reg_chk
      // R9
      req_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> wr_en);
      // R6
      be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en |-> $countones(wr_be) == int'($past(dst_bytes)));
   end else begin : g_comb_chk
      // R9
      req_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |-> wr_en);
      // R6
      be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en |-> $countones(wr_be) == int'(dst_bytes));
   end
endmodule

bind ldw_elem_placer ldw_elem_placer_chk #(
   .LANE_W  (LANE_W),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .dst_ovr_en   (dst_ovr_en),
   .dst_ovr_size (dst_ovr_size),
   .wr_en        (wr_en),
   .wr_be        (wr_be),
   .wr_data      (wr_data)
);

// File: tb/tb_ldw_elem_placer.sv
`timescale 1ns/1ps
module tb_ldw_elem_placer;
   localparam int unsigned IDX_W = 8;
   localparam int unsigned RN_W  = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] ld_data = '0;
   logic [1:0]  ld_size = '0, src_ovr_size = '0, dst_ovr_size = '0;
   logic        src_ovr_en = 1'b0, dst_ovr_en = 1'b0;
   logic [IDX_W-1:0] elem_idx = '0;
   logic [RN_W-1:0]  base_reg = '0;

   logic            r_en, c_en;
   logic [RN_W-1:0] r_reg, c_reg;
   logic [7:0]      r_be, c_be;
   logic [63:0]     r_data, c_data;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   ldw_elem_placer #(.IDX_W(IDX_W), .RN_W(RN_W), .OUT_REG(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ld_data(ld_data),
      .ld_size(ld_size), .src_ovr_en(src_ovr_en), .src_ovr_size(src_ovr_size),
      .dst_ovr_en(dst_ovr_en), .dst_ovr_size(dst_ovr_size), .elem_idx(elem_idx),
      .base_reg(base_reg), .wr_en(r_en), .wr_reg(r_reg), .wr_be(r_be), .wr_data(r_data));

   ldw_elem_placer #(.IDX_W(IDX_W), .RN_W(RN_W), .OUT_REG(1'b0)) dut_c (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ld_data(ld_data),
      .ld_size(ld_size), .src_ovr_en(src_ovr_en), .src_ovr_size(src_ovr_size),
      .dst_ovr_en(dst_ovr_en), .dst_ovr_size(dst_ovr_size), .elem_idx(elem_idx),
      .base_reg(base_reg), .wr_en(c_en), .wr_reg(c_reg), .wr_be(c_be), .wr_data(c_data));

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] wmask(input int c);
      return (c >= 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << c)) - 64'd1);
   endfunction

   logic        e_en;
   logic [4:0]  e_reg;
   logic [7:0]  e_be;
   logic [63:0] e_data;

   task automatic expect_calc();
      int sw, dw, mw, ew, bp;
      sw = src_ovr_en ? int'(src_ovr_size) : int'(ld_size);
      dw = dst_ovr_en ? int'(dst_ovr_size) : 3;
      mw = int'(ld_size);
      if (sw < mw) mw = sw;
      if (dw < mw) mw = dw;
      ew = 8 << dw;
      bp = int'(elem_idx) * ew;
      e_en   = in_valid;
      e_reg  = 5'((int'(base_reg) + bp / 64) % 32);
      e_data = in_valid ? ((ld_data & wmask(mw)) << (bp % 64)) : 64'd0;
      e_be   = in_valid ? 8'(((1 << (ew / 8)) - 1) << ((bp % 64) / 8)) : 8'd0;
   endtask

   function automatic logic [63:0] be_bits(input logic [7:0] be);
      logic [63:0] m;
      for (int b = 0; b < 8; b++) m[b*8 +: 8] = {8{be[b]}};
      return m;
   endfunction

   // drive at a negedge; check the combinational copy 1 ns later and the registered copy at the next negedge
   task automatic run_vec(input string tag);
      expect_calc();
      #1;
      chk(c_en == e_en, {tag, " R9 comb en"}, 64'(c_en), 64'(e_en));
      chk(c_data == e_data, {tag, " R3 R5 comb data"}, c_data, e_data);
      chk(c_be == e_be, {tag, " R6 comb be"}, 64'(c_be), 64'(e_be));
      if (e_en) chk(c_reg == e_reg, {tag, " R4 comb reg"}, 64'(c_reg), 64'(e_reg));
      @(negedge clk);
      chk(r_en == e_en, {tag, " R9 reg en"}, 64'(r_en), 64'(e_en));
      chk(r_data == e_data, {tag, " R3 R5 reg data"}, r_data, e_data);
      chk(r_be == e_be, {tag, " R6 reg be"}, 64'(r_be), 64'(e_be));
      chk((r_data & ~be_bits(r_be)) == 64'd0, {tag, " R7 outside be"}, r_data, 64'd0);
      if (e_en) chk(r_reg == e_reg, {tag, " R4 reg"}, 64'(r_reg), 64'(e_reg));
   endtask

   task automatic set_in(input logic v, input logic [1:0] ls, input logic se, input logic [1:0] ss,
                         input logic de, input logic [1:0] ds, input int idx);
      in_valid = v; ld_size = ls; src_ovr_en = se; src_ovr_size = ss;
      dst_ovr_en = de; dst_ovr_size = ds; elem_idx = IDX_W'(idx);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(r_en == 1'b0 && r_be == 8'd0, "R8 reset quiet", {56'd0, r_be}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      base_reg = 5'd29;
      ld_data  = 64'hAABB_CCDD_EEFF_1122;

      // R1: byte load keeps only bits 7:0
      set_in(1, 2'd0, 0, 2'd0, 0, 2'd0, 0);
      run_vec("R1");
      chk(r_data == 64'h22 && r_be == 8'hFF, "R1 byte load", r_data, 64'h22);
      // R2: halfword widened to 32, placed at index 1
      set_in(1, 2'd1, 1, 2'd2, 1, 2'd2, 1);
      run_vec("R2");
      chk(r_data == 64'h0000_1122_0000_0000 && r_be == 8'hF0, "R2 zero extend", r_data, 64'h0000_1122_0000_0000);
      // R2: doubleword truncated to 32, destination 64
      set_in(1, 2'd3, 1, 2'd2, 0, 2'd0, 0);
      run_vec("R2");
      chk(r_data == 64'hEEFF_1122, "R2 truncate", r_data, 64'hEEFF_1122);
      // R3: word load, source 16, no destination override, index 1 in next register
      set_in(1, 2'd2, 1, 2'd1, 0, 2'd0, 1);
      run_vec("R3");
      chk(r_data == 64'h1122 && r_reg == 5'd30, "R3 upper bits cleared", r_data, 64'h1122);
      // R5: halfword element 3 sits in the top two bytes
      set_in(1, 2'd3, 0, 2'd0, 1, 2'd1, 3);
      run_vec("R5");
      chk(r_data == 64'h1122_0000_0000_0000 && r_be == 8'hC0, "R5 lane offset", r_data, 64'h1122_0000_0000_0000);
      // R8: no valid, all outputs quiet
      set_in(0, 2'd3, 0, 2'd0, 0, 2'd0, 2);
      run_vec("R8");
      chk(r_en == 1'b0 && r_be == 8'd0 && r_data == 64'd0, "R8 idle", r_data, 64'd0);

      // full sweep
      for (int ls = 0; ls < 4; ls++)
         for (int se = 0; se < 2; se++)
            for (int ss = 0; ss < 4; ss++)
               for (int de = 0; de < 2; de++)
                  for (int ds = 0; ds < 4; ds++)
                     for (int j = 0; j < 20; j++) begin
                        ld_data  = 64'hF1E2_D3C4_B5A6_9788 ^ (64'(j) * 64'h0101_0305_0709_0B0D);
                        base_reg = 5'(27 + ls + j);
                        set_in(j != 7, 2'(ls), 1'(se), 2'(ss), 1'(de), 2'(ds), j);
                        run_vec("sweep");
                     end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #3_000_000;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule